// File: doc/BRIEF.md
# Banked Memory Window Mapper

This block sits between a 16-bit CPU and a memory system built from a base 64 KB of RAM, up to eight more 64 KB expansion banks, and two ROM overlays. It splits the CPU address space into four 16 KB windows. For each window it picks a physical RAM page from a small fixed set of layouts. It also decides whether a read is served by the lower ROM (window 0) or by the upper ROM (window 3).

Software writes a byte to the shared control port. A byte whose top two bits are both 1 is a mapping command. Its bits 5:3 choose the expansion bank and its bits 2:0 choose one of eight layouts. Bytes with any other top-bit pattern belong to other units on the same port, and this block ignores them.

Every result appears one clock after the access is presented. A separate video address path always lands in the base 64 KB. The physical RAM address is 20 bits wide and is formed as `{ext, bank[2:0], page[1:0], offset[13:0]}`. When `ext` is 0 the page lies in the base 64 KB and the bank field is zero.

Top module: `banked_mem_mapper`

## Requirements
- R1: A cycle with `io_wr`=1 and `io_data[7:6]`=2'b11 loads bank = `io_data[5:3]` and layout = `io_data[2:0]`. A port write with any other value in bits 7:6 leaves the mapping unchanged.
- R2: While `rst` is high, every output is zero. After reset the bank and the layout are both 0.
- R3: With layout 0, every CPU access maps flat into the base RAM: `ram_addr` = {4'b0000, cpu_addr}.
- R4: Layouts map windows 0..3 as follows, where "B" is a base page and "E" is a page of the selected bank. Layout 1: B0,B1,B2,E3. Layout 2: E0,E1,E2,E3. Layout 3: B0,B3,B2,E3. Layouts 4..7: B0, E(layout-4), B2, B3. A base page has ext=0 and bank=0. An expansion page has ext=1 and the selected bank.
- R5: A read (`cpu_rd`=1) in 0000-3FFF while `lo_rom_en`=1 gives `rom_sel`=1 and `rom_upper`=0.
- R6: A read in C000-FFFF while `hi_rom_en`=1 gives `rom_sel`=1 and `rom_upper`=1.
- R7: A write (`cpu_wr`=1) gives `ram_we`=1 and `rom_sel`=0, even when it falls inside an enabled ROM range.
- R8: A read in a ROM range whose enable is 0, and any read in 4000-BFFF, gives `rom_sel`=0. Such a read returns RAM.
- R9: `vid_ram_addr` = {4'b0000, vid_addr} one cycle later, whatever the mapping register holds.
- R10: Outputs are registered with a latency of one cycle. An access in the same cycle as a mapping write uses the old mapping. The new mapping applies from the next cycle on.
- R11: With neither `cpu_rd` nor `cpu_wr` high, `acc_valid`, `ram_we` and `rom_sel` are 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr | input | 1 | Write strobe on the shared control port |
| io_data | input | 8 | Byte written to the control port |
| cpu_rd | input | 1 | CPU memory read |
| cpu_wr | input | 1 | CPU memory write |
| cpu_addr | input | 16 | CPU address |
| lo_rom_en | input | 1 | Lower ROM overlay enable |
| hi_rom_en | input | 1 | Upper ROM overlay enable |
| vid_addr | input | 16 | Video fetch address |
| acc_valid | output | 1 | A CPU access was presented in the previous cycle |
| ram_we | output | 1 | The registered access is a RAM write |
| ram_addr | output | 20 | Physical RAM address {ext, bank, page, offset} |
| rom_sel | output | 1 | The read is served by a ROM |
| rom_upper | output | 1 | 1 selects the upper ROM, 0 the lower ROM |
| vid_ram_addr | output | 20 | Physical video address, always in the base 64 KB |

## Verification
The hardest case to reach is an access in the same cycle as a mapping write. It must still use the old mapping, and the bench only sees the effect one cycle later. The bench reaches it with a directed sequence: it writes a layout and issues an access into a swapped window in the same cycle, then repeats the access in the next cycle. Random stimulus also mixes mapping writes with accesses in the same cycle. A reference model updates its register only after it has computed the expected result for that cycle, so every such overlap is checked. Writes under enabled ROMs and foreign port codes come from both the random mix and directed steps.

// File: rtl/mmap_pkg.sv
package mmap_pkg;
  typedef struct packed {
    logic       ext;
    logic [1:0] page;
  } win_map_t;

  // layout number and window -> page source
  function automatic win_map_t win_lookup(input logic [2:0] lay, input logic [1:0] win);
    win_map_t m;
    m.ext  = 1'b0;
    m.page = win;
    case (lay)
      3'd1: if (win == 2'd3) m.ext = 1'b1;
      3'd2: m.ext = 1'b1;
      3'd3: begin
        if (win == 2'd3) m.ext = 1'b1;
        if (win == 2'd1) m.page = 2'd3;
      end
      3'd4, 3'd5, 3'd6, 3'd7: if (win == 2'd1) begin
        m.ext  = 1'b1;
        m.page = lay[1:0];
      end
      default: ;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/mmap_cfg_reg.sv
module mmap_cfg_reg #(
  parameter int BANK_W = 3,
  parameter int LAY_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_wr,
  input  logic [7:0]        io_data,
  output logic [BANK_W-1:0] bank_q,
  output logic [LAY_W-1:0]  lay_q
);
  logic hit;
  assign hit = io_wr && (io_data[7:6] == 2'b11);

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_q <= '0;
      lay_q  <= '0;
    end else if (hit) begin
      bank_q <= io_data[LAY_W +: BANK_W];
      lay_q  <= io_data[LAY_W-1:0];
    end
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(io_wr && io_data[7:6] == 2'b11) |=> ($stable(bank_q) && $stable(lay_q))); // R1
endmodule

// File: rtl/mmap_xlate.sv
module mmap_xlate
  import mmap_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BANK_W = 3,
  parameter int LAY_W  = 3,
  localparam int OFS_W  = ADDR_W - 2,
  localparam int PHYS_W = 1 + BANK_W + ADDR_W
) (
  input  logic [LAY_W-1:0]  lay,
  input  logic [BANK_W-1:0] bank,
  input  logic [ADDR_W-1:0] addr,
  output logic [PHYS_W-1:0] phys
);
  win_map_t tab [4];

  for (genvar w = 0; w < 4; w++) begin : g_win
    assign tab[w] = win_lookup(lay, 2'(w));
  end

  win_map_t sel;
  always_comb begin
    sel  = tab[addr[ADDR_W-1 -: 2]];
    phys = {sel.ext, (sel.ext ? bank : {BANK_W{1'b0}}), sel.page, addr[OFS_W-1:0]};
  end
endmodule

// File: rtl/mmap_rom_steer.sv
module mmap_rom_steer #(
  parameter int ADDR_W = 16
) (
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic              lo_en,
  input  logic              hi_en,
  output logic              sel,
  output logic              upper
);
  logic [1:0] win;
  assign win = addr[ADDR_W-1 -: 2];

  always_comb begin
    upper = (win == 2'd3);
    sel   = rd && (((win == 2'd0) && lo_en) || ((win == 2'd3) && hi_en));
  end
endmodule

// File: rtl/banked_mem_mapper.sv
module banked_mem_mapper #(
  parameter int ADDR_W = 16,
  parameter int BANK_W = 3,
  parameter int LAY_W  = 3,
  localparam int PHYS_W = 1 + BANK_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_wr,
  input  logic [7:0]        io_data,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              lo_rom_en,
  input  logic              hi_rom_en,
  input  logic [ADDR_W-1:0] vid_addr,
  output logic              acc_valid,
  output logic              ram_we,
  output logic [PHYS_W-1:0] ram_addr,
  output logic              rom_sel,
  output logic              rom_upper,
  output logic [PHYS_W-1:0] vid_ram_addr
);
  logic [BANK_W-1:0] bank_q;
  logic [LAY_W-1:0]  lay_q;
  logic [PHYS_W-1:0] phys_d;
  logic              rsel_d, rup_d;

  mmap_cfg_reg #(.BANK_W(BANK_W), .LAY_W(LAY_W)) u_cfg (
    .clk(clk), .rst(rst), .io_wr(io_wr), .io_data(io_data),
    .bank_q(bank_q), .lay_q(lay_q));

  mmap_xlate #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .LAY_W(LAY_W)) u_xl (
    .lay(lay_q), .bank(bank_q), .addr(cpu_addr), .phys(phys_d));

  mmap_rom_steer #(.ADDR_W(ADDR_W)) u_rom (
    .rd(cpu_rd), .addr(cpu_addr), .lo_en(lo_rom_en), .hi_en(hi_rom_en),
    .sel(rsel_d), .upper(rup_d));

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_valid    <= 1'b0;
      ram_we       <= 1'b0;
      ram_addr     <= '0;
      rom_sel      <= 1'b0;
      rom_upper    <= 1'b0;
      vid_ram_addr <= '0;
    end else begin
      acc_valid    <= cpu_rd || cpu_wr;
      ram_we       <= cpu_wr && !cpu_rd;
      ram_addr     <= phys_d;
      rom_sel      <= rsel_d && !cpu_wr;
      rom_upper    <= rup_d;
      vid_ram_addr <= {{(PHYS_W-ADDR_W){1'b0}}, vid_addr};
    end
  end

  AST_WRITE_NOT_ROM: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> !rom_sel); // R7
  AST_LO_ROM_RANGE: assert property (@(posedge clk) disable iff (rst)
    (rom_sel && !rom_upper) |-> (ram_addr[ADDR_W-1 -: 2] == 2'd0)); // R5
  AST_VID_BASE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (vid_ram_addr == {{(PHYS_W-ADDR_W){1'b0}}, $past(vid_addr)})); // R9
  AST_FLAT_MAP: assert property (@(posedge clk) disable iff (rst)
    (lay_q == '0 && cpu_rd) |=> (ram_addr == {{(PHYS_W-ADDR_W){1'b0}}, $past(cpu_addr)})); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !(cpu_rd || cpu_wr) |=> (!acc_valid && !ram_we && !rom_sel)); // R11
endmodule

// File: tb/banked_mem_mapper_test.sv
module banked_mem_mapper_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic io_wr = 1'b0;
  logic [7:0] io_data = '0;
  logic cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [15:0] cpu_addr = '0, vid_addr = '0;
  logic lo_rom_en = 1'b0, hi_rom_en = 1'b0;
  logic acc_valid, ram_we, rom_sel, rom_upper;
  logic [19:0] ram_addr, vid_ram_addr;

  int total = 0, bad = 0;
  logic [2:0] m_bank = '0, m_lay = '0;

  always #5 clk = ~clk;

  banked_mem_mapper uut (
    .clk(clk), .rst(rst), .io_wr(io_wr), .io_data(io_data),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .lo_rom_en(lo_rom_en), .hi_rom_en(hi_rom_en), .vid_addr(vid_addr),
    .acc_valid(acc_valid), .ram_we(ram_we), .ram_addr(ram_addr),
    .rom_sel(rom_sel), .rom_upper(rom_upper), .vid_ram_addr(vid_ram_addr));

  // reference: {ext, page} per window for each layout
  function automatic logic [19:0] ref_phys(input logic [2:0] lay, input logic [2:0] bank,
                                           input logic [15:0] a);
    logic [1:0] w;
    logic ext;
    logic [1:0] pg;
    w = a[15:14];
    ext = 1'b0;
    pg = w;
    if (lay == 3'd2) ext = 1'b1;
    else if ((lay == 3'd1 || lay == 3'd3) && w == 2'd3) ext = 1'b1;
    else if (lay == 3'd3 && w == 2'd1) pg = 2'd3;
    else if (lay >= 3'd4 && w == 2'd1) begin
      ext = 1'b1;
      pg = 2'(lay - 3'd4);
    end
    return {ext, ext ? bank : 3'd0, pg, a[13:0]};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, compare at the following negedge
  task automatic step(input logic iw, input logic [7:0] id, input logic rd, input logic wr,
                      input logic [15:0] a, input logic lo, input logic hi, input logic [15:0] va);
    logic [19:0] e_addr;
    logic e_sel, e_up, e_we, e_val;
    io_wr = iw; io_data = id; cpu_rd = rd; cpu_wr = wr; cpu_addr = a;
    lo_rom_en = lo; hi_rom_en = hi; vid_addr = va;
    e_addr = ref_phys(m_lay, m_bank, a);
    e_val = rd | wr;
    e_we = wr;
    e_up = (a[15:14] == 2'd3);
    e_sel = rd && !wr && ((a[15:14] == 2'd0 && lo) || (a[15:14] == 2'd3 && hi));
    if (iw && id[7:6] == 2'b11) begin
      m_bank = id[5:3];
      m_lay = id[2:0];
    end
    @(posedge clk);
    @(negedge clk);
    check(rd|wr ? "R11 acc_valid" : "R11 idle acc_valid", 32'(acc_valid), 32'(e_val));
    check(wr ? "R7 ram_we" : "R11 ram_we", 32'(ram_we), 32'(e_we));
    check(wr ? "R7 rom_sel on write" : (e_sel ? "R5/R6 rom_sel" : "R8 rom_sel"),
          32'(rom_sel), 32'(e_sel));
    if (e_sel) check(e_up ? "R6 rom_upper" : "R5 rom_upper", 32'(rom_upper), 32'(e_up));
    if (rd|wr) check(m_lay == 0 ? "R3 ram_addr" : "R4 ram_addr", 32'(ram_addr), 32'(e_addr));
    check("R9 vid_ram_addr", 32'(vid_ram_addr), 32'({4'h0, va}));
  endtask

  initial begin
    #(200000*10);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R2: reset state
    check("R2 acc_valid", 32'(acc_valid), 0);
    check("R2 ram_we", 32'(ram_we), 0);
    check("R2 ram_addr", 32'(ram_addr), 0);
    check("R2 rom_sel", 32'(rom_sel), 0);
    check("R2 vid_ram_addr", 32'(vid_ram_addr), 0);
    rst = 1'b0;
    // R2/R3: after reset, flat map
    step(0, 8'h00, 1, 0, 16'h9abc, 0, 0, 16'h1234);
    // R1: foreign codes ignored (layout stays 0)
    step(1, 8'h42, 0, 0, 16'h0, 0, 0, 16'h0);
    step(1, 8'h82, 1, 0, 16'h4321, 0, 0, 16'h0);
    check("R1 ignored code keeps flat map", 32'(ram_addr), 32'h04321);
    // R10: same-cycle write uses old mapping, next cycle uses new
    step(1, 8'hEA, 1, 0, 16'h5555, 0, 0, 16'hffff);   // bank 5 layout 2
    check("R10 same-cycle old map", 32'(ram_addr), 32'h05555);
    step(0, 8'h00, 1, 0, 16'h5555, 0, 0, 16'hffff);
    check("R10 R4 new map", 32'(ram_addr), 32'hD5555);
    // R7: write under enabled lower/upper ROM
    step(0, 8'h00, 0, 1, 16'h0100, 1, 1, 16'h0);
    step(0, 8'h00, 0, 1, 16'hC100, 1, 1, 16'h0);
    // R5/R6/R8
    step(0, 8'h00, 1, 0, 16'h0100, 1, 0, 16'h0);
    step(0, 8'h00, 1, 0, 16'hC100, 0, 1, 16'h0);
    step(0, 8'h00, 1, 0, 16'h0100, 0, 1, 16'h0);
    step(0, 8'h00, 1, 0, 16'h8100, 1, 1, 16'h0);
    // R4: every layout in every window, bank 6
    for (int l = 0; l < 8; l++) begin
      step(1, 8'(8'hC0 | (6 << 3) | l), 0, 0, 16'h0, 0, 0, 16'h0);
      for (int w = 0; w < 4; w++)
        step(0, 8'h00, 1, 0, 16'((w << 14) | 16'h0abc), 0, 0, 16'h0);
    end
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] d;
      logic [1:0] k;
      d = 8'($urandom);
      k = 2'($urandom);
      step($urandom_range(0, 3) == 0, d, k == 1, k == 2, 16'($urandom),
           1'($urandom), 1'($urandom), 16'($urandom));
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule